// File: doc/BRIEF.md
# DDR2 Low-Power Mode Controller

This block runs on the controller side of a DDR2 memory interface. It owns the clock-enable line to the memory and moves the device into and out of power-down and self-refresh. Other parts of the controller send single-cycle requests to enter a low-power state or to wake up. They also supply flags that describe the bank state and any mode-register or read/write activity that is still running. The block drives clock-enable and a forced-NOP flag for the command slot. Once the exit timing for the state just left has elapsed, it raises a command-permission output.

The power-down flavour is chosen at the moment of entry. If every bank is closed, the block uses precharge power-down. If a row is open, it uses active power-down, and the mode-register exit-select bit decides between fast exit and slow low-power exit. The wait after leaving self-refresh depends on the next command: a read waits the long delay and any other command waits the shorter one. A residency counter ends power-down without a wake request before the refresh deadline runs out. When an entry request arrives at a moment where entry is not allowed, the block keeps it pending instead of dropping it.

Top module: `ddr_lp_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `cke_o` = 1, `cmd_ok_o` = 1, `nop_o` = 0 and `dll_off_o` = 0.
- R2: A `pd_req_i` pulse accepted in idle sets `cke_o` = 0, `nop_o` = 1 and `cmd_ok_o` = 0 from the next cycle. `state_o` then shows the flavour: 1 (precharge) when `banks_idle_i` = 1. With a row open it shows 2 (fast active) when `slow_exit_i` = 0 and 3 (slow active) when `slow_exit_i` = 1.
- R3: No entry happens while `mrs_busy_i` or `rw_busy_i` is high. The request stays pending, and entry happens at the clock edge that ends the first cycle in which both flags are low.
- R4: Self-refresh (`state_o` = 4) is entered on `sr_req_i` only when `banks_idle_i` = 1 and neither busy flag is set. If both kinds of request are pending and self-refresh is legal, self-refresh is chosen.
- R5: A `wake_i` pulse in idle withdraws every pending entry request and leaves the outputs unchanged.
- R6: A `wake_i` pulse in a power-down state gives `cke_o` = 1 and `state_o` = 5 in the next cycle. `cmd_ok_o` first rises exactly D cycles after that first high-`cke_o` cycle. D is `T_XP` for precharge, `T_XARD` for fast active and `T_XARDS` for slow active power-down.
- R7: After a self-refresh exit, `cmd_ok_o` rises `T_XSNR` cycles after `cke_o` rises while `next_is_read_i` = 0, and `T_XSRD` cycles after while `next_is_read_i` = 1. `cmd_ok_o` follows the current value of `next_is_read_i`.
- R8: `dll_off_o` is 1 exactly in states 1, 3 and 4, and it is 0 in fast active power-down.
- R9: Power-down that receives no wake ends by itself after `PD_MAX_REFI*T_REFI-EXIT_MARGIN` cycles with `cke_o` low, followed by the normal exit delay. Self-refresh has no such limit.
- R10: `nop_o` is the inverse of `cmd_ok_o`, and `cmd_ok_o` is never 1 while `cke_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Single-cycle power-down entry request |
| sr_req_i | input | 1 | Single-cycle self-refresh entry request |
| wake_i | input | 1 | Single-cycle exit request (withdraws pending requests in idle) |
| banks_idle_i | input | 1 | All banks precharged |
| mrs_busy_i | input | 1 | Mode-register command time still running |
| rw_busy_i | input | 1 | Read or write burst still running |
| slow_exit_i | input | 1 | Mode-register exit select for active power-down: 0 fast, 1 slow |
| next_is_read_i | input | 1 | Next pending command is a read |
| cke_o | output | 1 | Clock enable to the memory |
| nop_o | output | 1 | Command slot forced to NOP/deselect |
| cmd_ok_o | output | 1 | Next command may issue |
| dll_off_o | output | 1 | Memory DLL is off in the current state |
| state_o | output | 3 | Current mode code (0 idle, 1 precharge PD, 2 fast PD, 3 slow PD, 4 self-refresh, 5 exit wait) |

## Verification
A wrong flavour choice appears on `state_o` and `dll_off_o` one cycle after the request. It also appears later as an exit delay that is too long or too short when `cmd_ok_o` rises. A corrupt exit counter only becomes visible at the end of the exit wait, up to `T_XSRD` cycles after wake. A lost pending request shows as `cke_o` staying high one cycle after the busy flags clear. A broken residency counter shows only at the deadline, as power-down that never ends or that ends early.

// File: rtl/ddr_lp_pkg.sv
`timescale 1ns/1ps
package ddr_lp_pkg;
  typedef enum logic [2:0] {
    LP_IDLE      = 3'd0,
    LP_PD_PRE    = 3'd1,
    LP_PD_FAST   = 3'd2,
    LP_PD_SLOW   = 3'd3,
    LP_SELF_REF  = 3'd4,
    LP_EXIT_WAIT = 3'd5
  } lp_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr_lp_downcnt.sv
`timescale 1ns/1ps
module ddr_lp_downcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_lp_entry.sv
`timescale 1ns/1ps
module ddr_lp_entry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arb_en_i,
  input  logic cancel_i,
  input  logic pd_req_i,
  input  logic sr_req_i,
  input  logic banks_idle_i,
  input  logic mrs_busy_i,
  input  logic rw_busy_i,
  output logic go_pd_o,
  output logic go_sr_o
);
  logic pend_pd_q, pend_sr_q;
  logic want_pd, want_sr, busy;

  assign want_pd = pend_pd_q | pd_req_i;
  assign want_sr = pend_sr_q | sr_req_i;
  assign busy    = mrs_busy_i | rw_busy_i;

  // self-refresh wins when both are legal
  assign go_sr_o = arb_en_i && !cancel_i && want_sr && !busy && banks_idle_i;
  assign go_pd_o = arb_en_i && !cancel_i && want_pd && !busy && !go_sr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_pd_q <= 1'b0;
      pend_sr_q <= 1'b0;
    end else if (cancel_i || go_sr_o || go_pd_o) begin
      pend_pd_q <= 1'b0;
      pend_sr_q <= 1'b0;
    end else begin
      pend_pd_q <= want_pd;
      pend_sr_q <= want_sr;
    end
  end
endmodule

// File: rtl/ddr_lp_ctrl.sv
`timescale 1ns/1ps
module ddr_lp_ctrl
  import ddr_lp_pkg::*;
#(
  parameter int T_XP        = 3,
  parameter int T_XARD      = 2,
  parameter int T_XARDS     = 6,
  parameter int T_XSNR      = 10,
  parameter int T_XSRD      = 200,
  parameter int T_REFI      = 1560,
  parameter int PD_MAX_REFI = 9,
  parameter int EXIT_MARGIN = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       wake_i,
  input  logic       banks_idle_i,
  input  logic       mrs_busy_i,
  input  logic       rw_busy_i,
  input  logic       slow_exit_i,
  input  logic       next_is_read_i,
  output logic       cke_o,
  output logic       nop_o,
  output logic       cmd_ok_o,
  output logic       dll_off_o,
  output logic [2:0] state_o
);
  localparam int EXIT_MAX   = imax(imax(T_XP, T_XARD), imax(T_XARDS, T_XSRD));
  localparam int EW         = $clog2(EXIT_MAX + 1);
  localparam int RES_CYC    = PD_MAX_REFI * T_REFI - EXIT_MARGIN;
  localparam int RW         = $clog2(RES_CYC + 1);
  localparam int SR_NR_LEFT = T_XSRD - T_XSNR;

  lp_state_e state_q, state_d;
  logic is_idle, in_pd, in_sr, in_wait;
  logic cancel, go_pd, go_sr;
  logic res_zero, res_expire, exit_go, exit_zero, sr_exit_q;
  logic [RW-1:0] res_cnt;
  logic [EW-1:0] exit_cnt, exit_val;

  assign is_idle = (state_q == LP_IDLE);
  assign in_sr   = (state_q == LP_SELF_REF);
  assign in_wait = (state_q == LP_EXIT_WAIT);
  assign in_pd   = (state_q == LP_PD_PRE) || (state_q == LP_PD_FAST) ||
                   (state_q == LP_PD_SLOW);
  assign cancel  = is_idle && wake_i;

  ddr_lp_entry i_entry (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arb_en_i     (is_idle),
    .cancel_i     (cancel),
    .pd_req_i     (pd_req_i),
    .sr_req_i     (sr_req_i),
    .banks_idle_i (banks_idle_i),
    .mrs_busy_i   (mrs_busy_i),
    .rw_busy_i    (rw_busy_i),
    .go_pd_o      (go_pd),
    .go_sr_o      (go_sr)
  );

  // residency limit: PD lasts at most RES_CYC cycles
  ddr_lp_downcnt #(.W(RW)) i_res_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (go_pd),
    .load_val_i (RW'(RES_CYC - 1)),
    .dec_i      (in_pd),
    .cnt_o      (res_cnt),
    .zero_o     (res_zero)
  );

  assign res_expire = in_pd && res_zero;
  assign exit_go    = (in_pd && (wake_i || res_expire)) || (in_sr && wake_i);

  always_comb begin
    unique case (state_q)
      LP_PD_PRE:   exit_val = EW'(T_XP);
      LP_PD_FAST:  exit_val = EW'(T_XARD);
      LP_PD_SLOW:  exit_val = EW'(T_XARDS);
      LP_SELF_REF: exit_val = EW'(T_XSRD);
      default:     exit_val = '0;
    endcase
  end

  ddr_lp_downcnt #(.W(EW)) i_exit_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (exit_go),
    .load_val_i (exit_val),
    .dec_i      (in_wait),
    .cnt_o      (exit_cnt),
    .zero_o     (exit_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_IDLE: begin
        if (go_sr)      state_d = LP_SELF_REF;
        else if (go_pd) state_d = banks_idle_i ? LP_PD_PRE :
                                  (slow_exit_i ? LP_PD_SLOW : LP_PD_FAST);
      end
      LP_PD_PRE, LP_PD_FAST, LP_PD_SLOW, LP_SELF_REF:
        if (exit_go) state_d = LP_EXIT_WAIT;
      LP_EXIT_WAIT:
        if (exit_zero) state_d = LP_IDLE;
      default: state_d = LP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LP_IDLE;
      sr_exit_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (exit_go) sr_exit_q <= in_sr;
    end
  end

  // non-read after self-refresh may go once T_XSNR has elapsed
  always_comb begin
    if (is_idle)      cmd_ok_o = 1'b1;
    else if (in_wait) cmd_ok_o = exit_zero ||
                                 (sr_exit_q && !next_is_read_i &&
                                  exit_cnt <= EW'(SR_NR_LEFT));
    else              cmd_ok_o = 1'b0;
  end

  assign cke_o     = is_idle || in_wait;
  assign nop_o     = !cmd_ok_o;
  assign dll_off_o = (state_q == LP_PD_PRE) || (state_q == LP_PD_SLOW) || in_sr;
  assign state_o   = state_q;
endmodule

// File: rtl/ddr_lp_ctrl_chk.sv
`timescale 1ns/1ps
module ddr_lp_ctrl_chk #(
  parameter int PD_LIMIT = 100,
  parameter int T_XSNR   = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       banks_idle_i,
  input logic       mrs_busy_i,
  input logic       rw_busy_i,
  input logic       cke_o,
  input logic       nop_o,
  input logic       cmd_ok_o,
  input logic       dll_off_o,
  input logic [2:0] state_o
);
  int pd_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_run <= 0;
    else if (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd3) pd_run <= pd_run + 1;
    else pd_run <= 0;
  end

  AST_CKE_LOW_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (nop_o && !cmd_ok_o)); // R10
  AST_ENTRY_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!$past(mrs_busy_i) && !$past(rw_busy_i))); // R3
  AST_SR_BANKS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cke_o) && state_o == 3'd4) |-> $past(banks_idle_i)); // R4
  AST_EXIT_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (state_o == 3'd5)); // R6
  AST_FAST_DLL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> !dll_off_o); // R8
  AST_PD_RESIDENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_run <= PD_LIMIT); // R9

  if (T_XSNR > 0) begin : g_sr_hold
    AST_SR_EXIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(cke_o) && $past(state_o) == 3'd4) |-> !cmd_ok_o); // R7
  end
endmodule

bind ddr_lp_ctrl ddr_lp_ctrl_chk #(
  .PD_LIMIT (PD_MAX_REFI * T_REFI - EXIT_MARGIN),
  .T_XSNR   (T_XSNR)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .banks_idle_i (banks_idle_i),
  .mrs_busy_i   (mrs_busy_i),
  .rw_busy_i    (rw_busy_i),
  .cke_o        (cke_o),
  .nop_o        (nop_o),
  .cmd_ok_o     (cmd_ok_o),
  .dll_off_o    (dll_off_o),
  .state_o      (state_o)
);

// File: tb/test_ddr_lp_ctrl.sv
`timescale 1ns/1ps
module test_ddr_lp_ctrl;
  localparam int T_XP = 3, T_XARD = 2, T_XARDS = 6, T_XSNR = 10, T_XSRD = 200;
  localparam int T_REFI = 20, PD_MAX_REFI = 9, EXIT_MARGIN = 8;
  localparam int RES_CYC = PD_MAX_REFI * T_REFI - EXIT_MARGIN;

  // [15] self-refresh, [14] banks idle, [13] slow exit, [12] next read,
  // [11:9] expected state, [8:0] expected exit delay
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 9'(T_XP)},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 9'(T_XP)},
    {1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 9'(T_XARD)},
    {1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 9'(T_XARDS)},
    {1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 9'(T_XSRD)},
    {1'b1, 1'b1, 1'b1, 1'b0, 3'd4, 9'(T_XSNR)},
    {1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 9'(T_XARDS)}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pd_req_i = 0, sr_req_i = 0, wake_i = 0, banks_idle_i = 1;
  logic mrs_busy_i = 0, rw_busy_i = 0, slow_exit_i = 0, next_is_read_i = 0;
  logic cke_o, nop_o, cmd_ok_o, dll_off_o;
  logic [2:0] state_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_lp_ctrl #(
    .T_XP(T_XP), .T_XARD(T_XARD), .T_XARDS(T_XARDS), .T_XSNR(T_XSNR),
    .T_XSRD(T_XSRD), .T_REFI(T_REFI), .PD_MAX_REFI(PD_MAX_REFI),
    .EXIT_MARGIN(EXIT_MARGIN)
  ) i_ddr_lp_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pd_req_i(pd_req_i), .sr_req_i(sr_req_i),
    .wake_i(wake_i), .banks_idle_i(banks_idle_i), .mrs_busy_i(mrs_busy_i),
    .rw_busy_i(rw_busy_i), .slow_exit_i(slow_exit_i),
    .next_is_read_i(next_is_read_i), .cke_o(cke_o), .nop_o(nop_o),
    .cmd_ok_o(cmd_ok_o), .dll_off_o(dll_off_o), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pd();
    pd_req_i = 1; step(1); pd_req_i = 0;
  endtask

  task automatic pulse_sr();
    sr_req_i = 1; step(1); sr_req_i = 0;
  endtask

  // wake, then count cycles from first high-cke cycle to cmd_ok
  task automatic wake_and_measure(input string req, output int n);
    wake_i = 1; step(1); wake_i = 0;
    chk({req, " cke high after wake"}, int'(cke_o), 1);
    chk({req, " exit-wait state"}, int'(state_o), 5);
    n = 0;
    while (!cmd_ok_o && n < 1000) begin step(1); n++; end
  endtask

  task automatic settle_idle();
    for (int k = 0; k < 300 && state_o != 3'd0; k++) step(1);
    step(1);
  endtask

  initial begin
    int n;
    step(2);
    chk("R1 state", int'(state_o), 0);
    chk("R1 cke", int'(cke_o), 1);
    chk("R1 cmd_ok", int'(cmd_ok_o), 1);
    chk("R1 nop", int'(nop_o), 0);
    chk("R1 dll_off", int'(dll_off_o), 0);
    rst_ni = 1; step(2);

    // table walk: R2 R4 R6 R7 R8
    for (int v = 0; v < 7; v++) begin
      banks_idle_i = VEC[v][14]; slow_exit_i = VEC[v][13]; next_is_read_i = VEC[v][12];
      if (VEC[v][15]) pulse_sr(); else pulse_pd();
      chk("R2/R4 state on entry", int'(state_o), int'(VEC[v][11:9]));
      chk("R2 cke low", int'(cke_o), 0);
      chk("R10 nop while low", int'(nop_o), 1);
      chk("R8 dll_off", int'(dll_off_o), (VEC[v][11:9] == 3'd2) ? 0 : 1);
      step(3);
      wake_and_measure("R6/R7", n);
      chk("R6/R7 exit delay", n, int'(VEC[v][8:0]));
      settle_idle();
    end
    banks_idle_i = 1; slow_exit_i = 0; next_is_read_i = 0;

    // R3: pending across rw busy
    rw_busy_i = 1; pulse_pd(); step(2);
    chk("R3 held while rw busy", int'(cke_o), 1);
    rw_busy_i = 0; step(1);
    chk("R3 entry after busy clears", int'(state_o), 1);
    wake_and_measure("R3", n); settle_idle();

    // R3: pending across mode-register busy
    mrs_busy_i = 1; pulse_pd(); step(3);
    chk("R3 held while mrs busy", int'(state_o), 0);
    mrs_busy_i = 0; step(1);
    chk("R3 entry after mrs clears", int'(cke_o), 0);
    wake_and_measure("R3", n); settle_idle();

    // R4: self-refresh waits for idle banks
    banks_idle_i = 0; pulse_sr(); step(2);
    chk("R4 no SR with open row", int'(state_o), 0);
    banks_idle_i = 1; step(1);
    chk("R4 SR after banks idle", int'(state_o), 4);
    wake_and_measure("R4", n); settle_idle();

    // R4: priority
    pd_req_i = 1; sr_req_i = 1; step(1); pd_req_i = 0; sr_req_i = 0;
    chk("R4 SR wins", int'(state_o), 4);
    wake_and_measure("R4", n); settle_idle();

    // R5: wake in idle withdraws pending request
    rw_busy_i = 1; pulse_pd();
    wake_i = 1; step(1); wake_i = 0;
    chk("R5 outputs unchanged", int'(cmd_ok_o), 1);
    rw_busy_i = 0; step(5);
    chk("R5 request withdrawn", int'(cke_o), 1);
    chk("R5 still idle", int'(state_o), 0);

    // R7: non-read allowed, then read not yet allowed
    next_is_read_i = 0; pulse_sr();
    step(2);
    wake_and_measure("R7", n);
    chk("R7 non-read delay", n, T_XSNR);
    next_is_read_i = 1; #1;
    chk("R7 read still blocked", int'(cmd_ok_o), 0);
    chk("R10 nop follows cmd_ok", int'(nop_o), 1);
    n = T_XSNR;
    while (!cmd_ok_o && n < 1000) begin step(1); n++; end
    chk("R7 read delay", n, T_XSRD);
    next_is_read_i = 0; settle_idle();

    // R9: forced exit from active power-down
    banks_idle_i = 0; slow_exit_i = 0; pulse_pd();
    n = 0;
    while (!cke_o && n < RES_CYC + 50) begin n++; step(1); end
    chk("R9 residency cycles", n, RES_CYC);
    chk("R9 exit-wait state", int'(state_o), 5);
    n = 0;
    while (!cmd_ok_o && n < 100) begin step(1); n++; end
    chk("R9 exit delay after forced exit", n, T_XARD);
    settle_idle();

    // R9: self-refresh is not limited
    banks_idle_i = 1; pulse_sr();
    step(RES_CYC + 20);
    chk("R9 SR unlimited", int'(state_o), 4);
    wake_and_measure("R9", n); settle_idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule